// File: doc/BRIEF.md
# Half-Bridge Gate Sequencer with Measured Dead Time

This block turns a single switching command into two gate enables for a half-bridge: one for the upper switch and one for the lower switch. It never asserts both enables at once. Each turn-on waits until a comparator reports that the opposite switch is really off, and then waits a further fixed number of clock cycles. The lower switch checks its own gate voltage. The upper switch is checked through the switch-node voltage.

Once the lower enable is on, it stays latched for the rest of the cycle, so ringing on the switch node cannot drop it. If the switch-node comparator never reports, a timeout forces the lower enable on anyway. A low-side permit input can veto the lower enable at any time and leaves the upper enable alone. Two undervoltage flags, one for each supply, force both enables low. After a fault, or after reset, the sequence restarts from an idle state. Every asynchronous input passes through a two-flop synchronizer, and both enables come from registers.

Top module: `half_bridge_sequencer`

## Requirements
- R1: After reset both enables are 0, and `hs_drive` and `ls_drive` are never 1 in the same cycle.
- R2: When `pwm_cmd` rises, `ls_drive` falls on the 3rd clock edge. `hs_drive` rises on the (3+TON_HI_CYC)th edge after `lo_gate_low` is seen high, and not before.
- R3: When `pwm_cmd` falls while the upper switch is on, `hs_drive` stays on and falls on the (3+TOFF_HI_CYC)th edge.
- R4: After `hs_drive` falls, `ls_drive` rises on the (3+TON_LO_CYC)th edge after `sw_node_low` rises. If the flag is already high when `hs_drive` falls, `ls_drive` rises 1+TON_LO_CYC edges after that fall.
- R5: Once on, `ls_drive` stays on until the next `pwm_cmd` rise, whatever `sw_node_low` does.
- R6: If `sw_node_low` stays low, `ls_drive` is forced on TMO_CYC edges after `hs_drive` falls.
- R7: `lo_permit` = 0 drives `ls_drive` to 0 on the 3rd edge and keeps it there, timeout included. `hs_drive` keeps its normal timing.
- R8: Setting `lo_permit` back to 1 during the low phase restores `ls_drive` on the 3rd edge.
- R9: Either `uv_core` or `uv_boot` = 1 drives both enables to 0 on the 3rd edge. After the flag clears, the sequence restarts from idle. With `pwm_cmd` high and `lo_gate_low` high, `hs_drive` rises on edge 4+TON_HI_CYC; with `pwm_cmd` low and `sw_node_low` high, `ls_drive` rises on edge 4+TON_LO_CYC.
- R10: A `pwm_cmd` high pulse of W cycles, with both flags held high, gives no `hs_drive` pulse when W < TON_HI_CYC+2. In that case `ls_drive` returns on edge 4+W+TON_LO_CYC.
- R11: With both flags held high and W >= TON_HI_CYC+2, the `hs_drive` pulse is W+TOFF_HI_CYC−TON_HI_CYC−1 cycles wide, and `ls_drive` returns on edge 4+W+TOFF_HI_CYC+TON_LO_CYC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_cmd | input | 1 | Switching command: 1 = upper on, 0 = lower on |
| lo_permit | input | 1 | 1 allows the lower enable, 0 vetoes it |
| lo_gate_low | input | 1 | Comparator: lower gate is below its off threshold |
| sw_node_low | input | 1 | Comparator: switch node has fallen below its threshold |
| uv_core | input | 1 | Undervoltage flag of the low-side supply |
| uv_boot | input | 1 | Undervoltage flag of the bootstrap supply |
| hs_drive | output | 1 | Upper gate enable |
| ls_drive | output | 1 | Lower gate enable |

## Verification
Every input reaches the sequencer after two synchronizer flops, and both enables are registered. A plain input change therefore shows at the outputs on the 3rd rising edge, and each timed phase adds its own parameter count. The bench drives inputs on falling edges and counts rising edges from that point. It samples the enables half a period after each edge and compares the edge count at which an enable first takes its new value against the count the requirement gives. The pulse-width sweep uses the same counting to predict the first and last upper-enable cycles and the return of the lower enable for every width.

// File: rtl/hb_seq_pkg.sv
package hb_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HI_WAIT,
    ST_HI_DLY,
    ST_HI_ON,
    ST_HO_FALL,
    ST_LO_WAIT,
    ST_LO_DLY,
    ST_LO_ON
  } hb_state_e;
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int               WIDTH   = 1,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/hb_dly_cnt.sv
module hb_dly_cnt #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign zero   = (cnt_q == '0);
  assign cnt_en = load | ~zero;

  always_comb begin
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/half_bridge_sequencer.sv
module half_bridge_sequencer
  import hb_seq_pkg::*;
#(
  parameter int TON_HI_CYC  = 3,
  parameter int TOFF_HI_CYC = 4,
  parameter int TON_LO_CYC  = 3,
  parameter int TMO_CYC     = 25,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_cmd,
  input  logic lo_permit,
  input  logic lo_gate_low,
  input  logic sw_node_low,
  input  logic uv_core,
  input  logic uv_boot,
  output logic hs_drive,
  output logic ls_drive
);
  localparam int MAX_A = (TON_HI_CYC > TOFF_HI_CYC) ? TON_HI_CYC : TOFF_HI_CYC;
  localparam int MAX_B = (TON_LO_CYC > TMO_CYC) ? TON_LO_CYC : TMO_CYC;
  localparam int MAX_D = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW    = $clog2(MAX_D + 1);
  localparam logic [CW-1:0] LD_TON_HI  = CW'(TON_HI_CYC - 1);
  localparam logic [CW-1:0] LD_TOFF_HI = CW'(TOFF_HI_CYC - 1);
  localparam logic [CW-1:0] LD_TON_LO  = CW'(TON_LO_CYC - 1);
  localparam logic [CW-1:0] LD_TMO     = CW'(TMO_CYC - 1);
  localparam int NSYNC = 6;

  // Synchronized inputs; undervoltage bits reset to the faulted level.
  logic [NSYNC-1:0] raw_in, sync_out;
  logic pwm_s, permit_s, lo_off_s, sw_low_s, uv_any;

  assign raw_in = {uv_boot, uv_core, sw_node_low, lo_gate_low, lo_permit, pwm_cmd};

  hb_sync #(
    .WIDTH  (NSYNC),
    .STAGES (SYNC_STAGES),
    .RST_VAL(6'b110000)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (raw_in),
    .q    (sync_out)
  );

  assign pwm_s    = sync_out[0];
  assign permit_s = sync_out[1];
  assign lo_off_s = sync_out[2];
  assign sw_low_s = sync_out[3];
  assign uv_any   = sync_out[4] | sync_out[5];

  // Shared phase timer
  logic          tmr_load, tmr_zero;
  logic [CW-1:0] tmr_val;

  hb_dly_cnt #(.CW(CW)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .load_val(tmr_val),
    .zero    (tmr_zero)
  );

  hb_state_e st_q, st_d;
  logic      hs_q, ls_q, hs_d, ls_d;

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (uv_any) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (pwm_s) st_d = ST_HI_WAIT;
          else begin st_d = ST_LO_WAIT; tmr_load = 1'b1; tmr_val = LD_TMO; end
        end
        ST_HI_WAIT: begin
          if (!pwm_s) begin st_d = ST_LO_WAIT; tmr_load = 1'b1; tmr_val = LD_TMO; end
          else if (lo_off_s) begin st_d = ST_HI_DLY; tmr_load = 1'b1; tmr_val = LD_TON_HI; end
        end
        ST_HI_DLY: begin
          if (!pwm_s) begin st_d = ST_LO_WAIT; tmr_load = 1'b1; tmr_val = LD_TMO; end
          else if (tmr_zero) st_d = ST_HI_ON;
        end
        ST_HI_ON: begin
          if (!pwm_s) begin st_d = ST_HO_FALL; tmr_load = 1'b1; tmr_val = LD_TOFF_HI; end
        end
        ST_HO_FALL: begin
          if (pwm_s) st_d = ST_HI_ON;
          else if (tmr_zero) begin st_d = ST_LO_WAIT; tmr_load = 1'b1; tmr_val = LD_TMO; end
        end
        ST_LO_WAIT: begin
          if (pwm_s) st_d = ST_HI_WAIT;
          else if (sw_low_s) begin st_d = ST_LO_DLY; tmr_load = 1'b1; tmr_val = LD_TON_LO; end
          else if (tmr_zero) st_d = ST_LO_ON;
        end
        ST_LO_DLY: begin
          if (pwm_s) st_d = ST_HI_WAIT;
          else if (tmr_zero) st_d = ST_LO_ON;
        end
        ST_LO_ON: begin
          if (pwm_s) st_d = ST_HI_WAIT;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  assign hs_d = ((st_d == ST_HI_ON) || (st_d == ST_HO_FALL)) && !uv_any;
  assign ls_d = (st_d == ST_LO_ON) && permit_s && !uv_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      hs_q <= 1'b0;
      ls_q <= 1'b0;
    end else begin
      st_q <= st_d;
      hs_q <= hs_d;
      ls_q <= ls_d;
    end
  end

  assign hs_drive = hs_q;
  assign ls_drive = ls_q;

  assert_no_overlap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_q && ls_q));
  assert_hs_after_ls_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_q) |-> !$past(ls_q));
  assert_ls_after_hs_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_q) |-> !$past(hs_q));
  assert_ls_latched_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_q && !pwm_s && permit_s && !uv_any) |=> ls_q);
  assert_permit_veto_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !permit_s |=> !ls_q);
  assert_uv_kill_R9: assert property (@(posedge clk) disable iff (!rst_n)
    uv_any |=> (!hs_q && !ls_q));
endmodule

// File: tb/sim_half_bridge_sequencer.sv
module sim_half_bridge_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int TON_HI  = 3;
  localparam int TOFF_HI = 4;
  localparam int TON_LO  = 3;
  localparam int TMO     = 25;

  logic clk = 1'b0;
  logic rst_n;
  logic pwm_cmd, lo_permit, lo_gate_low, sw_node_low, uv_core, uv_boot;
  logic hs_drive, ls_drive;
  int   errs   = 0;
  int   checks = 0;
  bit   done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  half_bridge_sequencer #(
    .TON_HI_CYC (TON_HI),
    .TOFF_HI_CYC(TOFF_HI),
    .TON_LO_CYC (TON_LO),
    .TMO_CYC    (TMO),
    .SYNC_STAGES(2)
  ) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwm_cmd    (pwm_cmd),
    .lo_permit  (lo_permit),
    .lo_gate_low(lo_gate_low),
    .sw_node_low(sw_node_low),
    .uv_core    (uv_core),
    .uv_boot    (uv_boot),
    .hs_drive   (hs_drive),
    .ls_drive   (ls_drive)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  // Counts edges from now; reports the edge at which the chosen enable first equals val.
  task automatic expect_at(input bit sel_ls, input bit val, input int n, input string tag);
    int first;
    first = -1;
    for (int i = 1; i <= n; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (((sel_ls ? ls_drive : hs_drive) == val) && first < 0) first = i;
    end
    chk(tag, first, n);
  endtask

  // Pulse of W cycles on pwm_cmd with both comparator flags held high.
  task automatic sweep_width(input int w);
    int hs_first, hs_cnt, ls_low, ls_back, ovl, exp_first, exp_cnt, exp_back;
    bit pre_ok;
    hs_first = -1; hs_cnt = 0; ls_low = -1; ls_back = -1; ovl = 0; pre_ok = 1'b1;
    pwm_cmd = 1'b1;
    for (int k = 1; k <= 40; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (hs_drive && ls_drive) ovl++;
      if (hs_drive) begin
        hs_cnt++;
        if (hs_first < 0) hs_first = k;
      end
      if (k < 3 && !ls_drive) pre_ok = 1'b0;
      if (!ls_drive && ls_low < 0) ls_low = k;
      if (ls_drive && ls_low > 0 && ls_back < 0) ls_back = k;
      if (k == w) pwm_cmd = 1'b0;
    end
    if (w >= TON_HI + 2) begin
      exp_first = 4 + TON_HI;
      exp_cnt   = w + TOFF_HI - TON_HI - 1;
      exp_back  = 4 + w + TOFF_HI + TON_LO;
    end else begin
      exp_first = -1;
      exp_cnt   = 0;
      exp_back  = 4 + w + TON_LO;
    end
    chk($sformatf("R2 sweep w=%0d ls falls on edge 3", w), pre_ok ? ls_low : -1, 3);
    chk($sformatf("R11 R10 sweep w=%0d hs first edge", w), hs_first, exp_first);
    chk($sformatf("R11 R10 sweep w=%0d hs width", w), hs_cnt, exp_cnt);
    chk($sformatf("R11 R10 sweep w=%0d ls return edge", w), ls_back, exp_back);
    chk($sformatf("R1 sweep w=%0d overlap cycles", w), ovl, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int bad;
    rst_n = 1'b0;
    pwm_cmd = 1'b0; lo_permit = 1'b1; lo_gate_low = 1'b1; sw_node_low = 1'b1;
    uv_core = 1'b0; uv_boot = 1'b0;
    tick(3);
    chk("R1 reset hs", hs_drive, 0);
    chk("R1 reset ls", ls_drive, 0);
    rst_n = 1'b1;
    tick(2);
    chk("R1 after reset hs", hs_drive, 0);
    tick(20);
    chk("R4 idle settles into low phase", ls_drive, 1);

    for (int w = 1; w <= 12; w++) begin
      sweep_width(w);
      tick(8);
    end

    // R2: upper waits for the lower-gate-off flag
    lo_gate_low = 1'b0;
    pwm_cmd = 1'b1;
    tick(12);
    chk("R2 hs held while lower gate not off", hs_drive, 0);
    chk("R2 ls off after command rise", ls_drive, 0);
    lo_gate_low = 1'b1;
    expect_at(1'b0, 1'b1, 3 + TON_HI, "R2 hs rise after flag");

    // R3 then R6: falling command, no switch-node flag
    sw_node_low = 1'b0;
    pwm_cmd = 1'b0;
    expect_at(1'b0, 1'b0, 3 + TOFF_HI, "R3 hs fall delay");
    expect_at(1'b1, 1'b1, TMO, "R6 timeout forces ls");

    // R5: ringing on switch-node flag while latched
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      sw_node_low = ~sw_node_low;
      @(posedge clk);
      @(negedge clk);
      if (!ls_drive) bad++;
    end
    tick(4);
    if (!ls_drive) bad++;
    chk("R5 ls stays latched under ringing", bad, 0);

    // R4: flag arrives late
    sw_node_low = 1'b1;
    pwm_cmd = 1'b1;
    tick(15);
    sw_node_low = 1'b0;
    pwm_cmd = 1'b0;
    expect_at(1'b0, 1'b0, 3 + TOFF_HI, "R3 hs fall before late flag");
    tick(3);
    sw_node_low = 1'b1;
    expect_at(1'b1, 1'b1, 3 + TON_LO, "R4 ls rise after switch-node flag");

    // R7 / R8: permit veto part-way through
    lo_permit = 1'b0;
    expect_at(1'b1, 1'b0, 3, "R7 ls killed by permit");
    pwm_cmd = 1'b1;
    expect_at(1'b0, 1'b1, 4 + TON_HI, "R7 hs unaffected by veto");
    sw_node_low = 1'b0;
    pwm_cmd = 1'b0;
    expect_at(1'b0, 1'b0, 3 + TOFF_HI, "R7 hs fall under veto");
    tick(TMO + 10);
    chk("R7 timeout does not force ls while vetoed", ls_drive, 0);
    lo_permit = 1'b1;
    expect_at(1'b1, 1'b1, 3, "R8 ls restored by permit");
    sw_node_low = 1'b1;

    // R9: undervoltage faults
    pwm_cmd = 1'b1;
    tick(15);
    chk("R9 hs on before fault", hs_drive, 1);
    uv_boot = 1'b1;
    expect_at(1'b0, 1'b0, 3, "R9 boot fault drops hs");
    tick(10);
    chk("R9 hs held low in fault", hs_drive, 0);
    chk("R9 ls held low in fault", ls_drive, 0);
    uv_boot = 1'b0;
    expect_at(1'b0, 1'b1, 4 + TON_HI, "R9 hs restart after fault");
    pwm_cmd = 1'b0;
    tick(30);
    chk("R9 ls on before core fault", ls_drive, 1);
    uv_core = 1'b1;
    expect_at(1'b1, 1'b0, 3, "R9 core fault drops ls");
    tick(6);
    uv_core = 1'b0;
    expect_at(1'b1, 1'b1, 4 + TON_LO, "R9 ls restart after fault");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule